// File: doc/BRIEF.md
# Resampling Phase and Cubic Weight Generator

This block is the control half of a polyphase sample-rate converter. It tracks where each output sample falls on the input sample grid. On every output request it adds a programmable step to a fixed-point fraction register. The step is the ratio of input rate to output rate, in input samples per output sample. From the sum the block reports three values: how many whole input samples the filter datapath must consume, which stored subfilter phase applies, and four cubic interpolation weights. The datapath uses those weights to blend four neighbouring subfilters into one effective filter.

The step value can be changed between requests, so an external rate-tracking loop can steer the conversion ratio over time. The subfilter index is taken as a plain floor of the scaled fraction, so it never goes negative. The cost of this is a fixed extra delay, which the filter bank absorbs. All the math is fixed-point. The fraction register has 32 bits. The step has 8 integer bits and 32 fractional bits. The weights are 19-bit two's complement values with 16 fractional bits, so 1.0 is 65536.

Top module: `resample_phase_gen`

## Requirements
- R1: After reset, valid_o is 0, the fraction register is 0 and the step register holds 1.0 (40'h01_0000_0000). A first request with no load therefore returns step_o = 1, phase_o = 0 and weights (0, 65536, 0, 0).
- R2: When req_i is high at a rising edge, the 32-bit fraction f is replaced by (f + ratio) mod 2^32. At the next edge valid_o is 1 and step_o (9 bits) equals floor((f + ratio) / 2^32). valid_o is 0 in any cycle that does not follow a request.
- R3: phase_o equals fraction bits [31:28], which is floor(16 * f) for the default of 16 phases.
- R4: The local fraction tc used for the weights is fraction bits [27:12], read as an unsigned value divided by 65536.
- R5: The weights follow the cubic Lagrange form, scaled by 65536, within 8 LSB:
  - wa = -tc^3/6 + tc^2/2 - tc/3
  - wb = tc^3/2 - tc^2 - tc/2 + 1
  - wc = -tc^3/2 + tc^2/2 + tc
  - wd = tc^3/6 - tc/6
- R6: When tc = 0, the weights are exactly (0, 65536, 0, 0).
- R7: For every tc, wa + wb + wc + wd is within 1 LSB of 65536.
- R8: A pulse on ratio_ld_i with req_i low loads ratio_i into the step register. The new value takes effect from the next request.
- R9: A ratio_ld_i pulse in the same cycle as req_i is dropped. That request, and the ones after it, keep using the previous step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ratio_i | input | 40 | Step value, unsigned, 8 integer and 32 fraction bits |
| ratio_ld_i | input | 1 | Load strobe for the step register |
| req_i | input | 1 | Output-sample request |
| valid_o | output | 1 | Result of a request is present |
| step_o | output | 9 | Whole input samples to consume |
| phase_o | output | 4 | Subfilter index |
| wa_o | output | 19 | Weight for subfilter phase k, signed Q3.16 |
| wb_o | output | 19 | Weight for phase k+1 |
| wc_o | output | 19 | Weight for phase k+2 |
| wd_o | output | 19 | Weight for phase k+3 |

## Verification
The accumulator is driven with several kinds of step:
- Steps below one, which produce runs of zero-sample advances.
- Steps just above one, with irrational-looking fractions, which move tc through the whole interval.
- Large steps, up to the maximum, which exercise the carry into the top bit of step_o.
- Steps that are exact multiples of the phase spacing, which hold tc at zero and separate the exact-identity case from the general formula.

A one-LSB step shows that the low fraction bits accumulate even when the index and weights barely move. The load-during-request case separates a correct ratio update from one that leaks into the running sequence.

// File: rtl/resample_pkg.sv
package resample_pkg;
  localparam int unsigned STEP_INT_W  = 8;
  localparam int unsigned STEP_FRAC_W = 32;
  localparam int unsigned PHASES      = 16;
  localparam int unsigned TC_BITS     = 16;
endpackage

// File: rtl/resample_phase_acc.sv
module resample_phase_acc #(
  parameter int unsigned INT_W  = resample_pkg::STEP_INT_W,
  parameter int unsigned FRAC_W = resample_pkg::STEP_FRAC_W,
  localparam int unsigned RATIO_W = INT_W + FRAC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               ratio_ld_i,
  input  logic               req_i,
  output logic               valid_o,
  output logic [INT_W:0]     step_o,
  output logic [FRAC_W-1:0]  frac_o
);
  localparam logic [RATIO_W-1:0] RATIO_ONE = RATIO_W'(1) << FRAC_W;

  logic [RATIO_W-1:0] ratio_q;
  logic [FRAC_W-1:0]  frac_q;
  logic [INT_W:0]     step_q;
  logic               valid_q;
  logic [RATIO_W:0]   sum;

  assign sum = {{(INT_W + 1){1'b0}}, frac_q} + {1'b0, ratio_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_q <= RATIO_ONE;
      frac_q  <= '0;
      step_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_i;
      if (req_i) begin
        frac_q <= sum[FRAC_W-1:0];
        step_q <= sum[RATIO_W:FRAC_W];
      end else if (ratio_ld_i) begin
        ratio_q <= ratio_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign step_o  = step_q;
  assign frac_o  = frac_q;

  // R2
  req_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  // R2
  idle_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  // R8
  ratio_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ratio_ld_i && !req_i) |=> (ratio_q == $past(ratio_i)));
  // R9
  ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> $stable(ratio_q));
  // R2
  frac_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(frac_o));
endmodule

// File: rtl/resample_phase_split.sv
module resample_phase_split #(
  parameter int unsigned FRAC_W = resample_pkg::STEP_FRAC_W,
  parameter int unsigned M      = resample_pkg::PHASES,
  parameter int unsigned TC_W   = resample_pkg::TC_BITS,
  localparam int unsigned K_W   = $clog2(M),
  localparam int unsigned REM_W = FRAC_W - K_W
) (
  input  logic [FRAC_W-1:0] frac_i,
  output logic [K_W-1:0]    phase_o,
  output logic [TC_W-1:0]   tc_o
);
  logic [REM_W-1:0] rem;

  assign phase_o = frac_i[FRAC_W-1 -: K_W];
  assign rem     = frac_i[REM_W-1:0];

  generate
    if (REM_W >= TC_W) begin : g_trunc
      assign tc_o = TC_W'(rem >> (REM_W - TC_W));
    end else begin : g_pad
      assign tc_o = {rem, {(TC_W - REM_W){1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/resample_cubic_weights.sv
module resample_cubic_weights #(
  parameter int unsigned TC_W = resample_pkg::TC_BITS,
  localparam int unsigned W_W = TC_W + 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [TC_W-1:0]       tc_i,
  output logic signed [W_W-1:0] wa_o,
  output logic signed [W_W-1:0] wb_o,
  output logic signed [W_W-1:0] wc_o,
  output logic signed [W_W-1:0] wd_o
);
  localparam logic signed [W_W-1:0] ONE = W_W'(1) << TC_W;
  localparam logic signed [W_W-1:0] SIX = W_W'(6);

  logic [2*TC_W-1:0] sq, cu;
  logic [TC_W-1:0]   t2, t3;
  logic signed [W_W-1:0] t1_s, t2_s, t3_s, num_a, num_c, num_d;

  assign sq = tc_i * tc_i;
  assign t2 = TC_W'(sq >> TC_W);
  assign cu = t2 * tc_i;
  assign t3 = TC_W'(cu >> TC_W);

  assign t1_s = $signed({3'b000, tc_i});
  assign t2_s = $signed({3'b000, t2});
  assign t3_s = $signed({3'b000, t3});

  // 6*wa, 2*wc, 6*wd in units of 2^-TC_W
  assign num_a = t2_s + t2_s + t2_s - t3_s - t1_s - t1_s;
  assign num_c = t2_s - t3_s + t1_s + t1_s;
  assign num_d = t3_s - t1_s;

  assign wa_o = num_a / SIX;
  assign wc_o = num_c >>> 1;
  assign wd_o = num_d / SIX;
  // wb closes the partition of unity
  assign wb_o = ONE - wa_o - wc_o - wd_o;

  // R6
  zero_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i == '0) |-> (wa_o == '0 && wc_o == '0 && wd_o == '0 && wb_o == ONE));
  // R5
  weight_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wc_o >= 0) && (wd_o <= 0));
endmodule

// File: rtl/resample_phase_gen.sv
module resample_phase_gen #(
  parameter int unsigned INT_W  = resample_pkg::STEP_INT_W,
  parameter int unsigned FRAC_W = resample_pkg::STEP_FRAC_W,
  parameter int unsigned M      = resample_pkg::PHASES,
  parameter int unsigned TC_W   = resample_pkg::TC_BITS,
  localparam int unsigned K_W   = $clog2(M),
  localparam int unsigned W_W   = TC_W + 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [INT_W+FRAC_W-1:0]   ratio_i,
  input  logic                      ratio_ld_i,
  input  logic                      req_i,
  output logic                      valid_o,
  output logic [INT_W:0]            step_o,
  output logic [K_W-1:0]            phase_o,
  output logic signed [W_W-1:0]     wa_o,
  output logic signed [W_W-1:0]     wb_o,
  output logic signed [W_W-1:0]     wc_o,
  output logic signed [W_W-1:0]     wd_o
);
  logic [FRAC_W-1:0] frac;
  logic [TC_W-1:0]   tc;

  resample_phase_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_acc (
    .clk_i, .rst_ni, .ratio_i, .ratio_ld_i, .req_i,
    .valid_o, .step_o, .frac_o(frac)
  );

  resample_phase_split #(.FRAC_W(FRAC_W), .M(M), .TC_W(TC_W)) u_split (
    .frac_i(frac), .phase_o, .tc_o(tc)
  );

  resample_cubic_weights #(.TC_W(TC_W)) u_wgt (
    .clk_i, .rst_ni, .tc_i(tc), .wa_o, .wb_o, .wc_o, .wd_o
  );
endmodule

// File: tb/resample_phase_gen_tb.sv
module resample_phase_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [39:0] ratio_i = '0;
  logic        ratio_ld_i = 1'b0;
  logic        req_i = 1'b0;
  logic        valid_o;
  logic [8:0]  step_o;
  logic [3:0]  phase_o;
  logic signed [18:0] wa_o, wb_o, wc_o, wd_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  longint frac_m;
  longint ratio_m;

  resample_phase_gen dut_i (
    .clk_i, .rst_ni, .ratio_i, .ratio_ld_i, .req_i,
    .valid_o, .step_o, .phase_o, .wa_o, .wb_o, .wc_o, .wd_o
  );

  always #10 clk_i = ~clk_i;

  // {ratio, request count}
  localparam logic [47:0] VEC [8] = '{
    {40'h00_9999_999A, 8'd12},
    {40'h01_1666_6666, 8'd10},
    {40'h02_8000_0000, 8'd4},
    {40'h00_0800_0000, 8'd20},
    {40'h00_1000_0000, 8'd8},
    {40'h03_0000_0001, 8'd4},
    {40'h00_0000_1000, 8'd6},
    {40'hFF_FF_FFFF_FF, 8'd3}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic real absr(input real v);
    return (v < 0.0) ? -v : v;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic load_ratio(input logic [39:0] r);
    @(negedge clk_i);
    ratio_i = r; ratio_ld_i = 1'b1;
    @(negedge clk_i);
    ratio_ld_i = 1'b0;
    ratio_m = longint'(r);
  endtask

  task automatic check_weights();
    longint tcb;
    real t, ea, eb, ec, ed;
    longint s;
    tcb = (frac_m >> 12) & 64'hFFFF;
    t = real'(tcb) / 65536.0;
    ea = 65536.0 * (-t*t*t/6.0 + t*t/2.0 - t/3.0);
    eb = 65536.0 * (t*t*t/2.0 - t*t - t/2.0 + 1.0);
    ec = 65536.0 * (-t*t*t/2.0 + t*t/2.0 + t);
    ed = 65536.0 * (t*t*t/6.0 - t/6.0);
    chk(absr(real'(wa_o) - ea) <= 8.0, "R4/R5 wa", longint'(wa_o), longint'(ea));
    chk(absr(real'(wb_o) - eb) <= 8.0, "R4/R5 wb", longint'(wb_o), longint'(eb));
    chk(absr(real'(wc_o) - ec) <= 8.0, "R4/R5 wc", longint'(wc_o), longint'(ec));
    chk(absr(real'(wd_o) - ed) <= 8.0, "R4/R5 wd", longint'(wd_o), longint'(ed));
    s = longint'(wa_o) + longint'(wb_o) + longint'(wc_o) + longint'(wd_o);
    chk(s >= 65535 && s <= 65537, "R7 weight sum", s, 65536);
    if (tcb == 0) begin
      // R6 exact identity at tc = 0
      chk(wa_o == 0 && wc_o == 0 && wd_o == 0 && wb_o == 19'sd65536, "R6 tc=0 weights",
          longint'(wb_o), 65536);
    end
  endtask

  task automatic do_req(input bit with_ld, input logic [39:0] ld_val);
    longint sum;
    longint exp_step;
    @(negedge clk_i);
    req_i = 1'b1;
    if (with_ld) begin ratio_i = ld_val; ratio_ld_i = 1'b1; end
    @(negedge clk_i);
    req_i = 1'b0; ratio_ld_i = 1'b0;
    sum = frac_m + ratio_m;
    exp_step = sum >>> 32;
    frac_m = sum & 64'hFFFF_FFFF;
    chk(valid_o == 1'b1, "R2 valid after request", longint'(valid_o), 1);
    chk(longint'(step_o) == exp_step, "R2 step", longint'(step_o), exp_step);
    chk(longint'(phase_o) == (frac_m >> 28), "R3 phase", longint'(phase_o), frac_m >> 28);
    check_weights();
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; req_i = 1'b0; ratio_ld_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    frac_m = 0;
    ratio_m = 64'h1_0000_0000;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk_i);
    // R1 reset state
    chk(valid_o == 1'b0, "R1 valid after reset", longint'(valid_o), 0);
    chk(wb_o == 19'sd65536 && wa_o == 0, "R1 weights after reset", longint'(wb_o), 65536);
    // R1 default ratio is 1.0
    do_req(1'b0, '0);
    chk(step_o == 9'd1 && phase_o == 4'd0, "R1 default step", longint'(step_o), 1);
    @(negedge clk_i);
    chk(valid_o == 1'b0, "R2 valid low when idle", longint'(valid_o), 0);

    for (int v = 0; v < 8; v++) begin
      load_ratio(VEC[v][47:8]);
      for (int r = 0; r < int'(VEC[v][7:0]); r++) do_req(1'b0, '0);
      @(negedge clk_i);
      chk(valid_o == 1'b0, "R2 valid low when idle", longint'(valid_o), 0);
    end

    // R6: phase-aligned steps keep tc at zero
    do_reset();
    load_ratio(40'h00_1000_0000);
    for (int r = 0; r < 20; r++) do_req(1'b0, '0);

    // R8: new ratio applies from the next request
    load_ratio(40'h02_4000_0000);
    do_req(1'b0, '0);
    chk(step_o >= 9'd2, "R8 loaded ratio used", longint'(step_o), 2);

    // R9: load together with a request is dropped
    do_req(1'b1, 40'h05_0000_0000);
    do_req(1'b0, '0);
    chk(step_o < 9'd5, "R9 coincident load dropped", longint'(step_o), 2);

    finish_run();
  end
endmodule